// File: doc/BRIEF.md
# MD5 Single-Block Compression Engine

This engine takes one 512-bit block that has already been padded and turns it into a 128-bit MD5 digest. It holds the chaining state in four 32-bit words, A, B, C and D, and performs one MD5 step per clock. The 64 steps take 64 clocks. The step constants, the rotation amounts and the message-word selection are generated inside the block, so a caller supplies only the block.

A block is accepted with a valid/ready handshake. The engine then ignores its input until the digest has been consumed. The digest is offered with a valid flag and is held under back-pressure. While no digest is valid, the output shows the little-endian image of the initial chaining value. Padding, length encoding and chaining over several blocks are the caller's job.

Top module: `md5_engine`

## Requirements
- R1: After reset, and whenever the engine is idle, in_ready_o is 1, digest_valid_o is 0 and digest_o is 128'h0123456789abcdeffedcba9876543210. in_ready_o and digest_valid_o are never high together.
- R2: A block is taken on a rising edge where in_valid_i and in_ready_o are both high. From the next cycle, in_ready_o stays low until the digest has been taken.
- R3: digest_valid_o rises on the 64th rising edge after the edge that took the block, and stays low before that edge.
- R4: While a block is being processed, digest_o shows 128'h0123456789abcdeffedcba9876543210.
- R5: The digest equals the MD5 compression of the block, starting from A=0x67452301, B=0xefcdab89, C=0x98badcfe and D=0x10325476. Each step uses the round function for its group of 16 steps (F, G, H, I), the word index, the rotation amount and the constant floor(2^32·|sin(i+1)|) for its step. The four words then rotate (new A = old D, new B = step result, new C = old B, new D = old C). At the end the initial value is added to each word modulo 2^32.
- R6: Message byte n sits in block_i[8n+7:8n], so word j is block_i[32j+31:32j]. Digest byte n sits in digest_o[127-8n:120-8n]. Byte 0 is the low byte of A and byte 15 is the high byte of D.
- R7: The padded blocks of "", "abc" and "message digest" give d41d8cd98f00b204e9800998ecf8427e, 900150983cd24fb0d6963f7d28e17f72 and f96b697d7cb7938d525a2f31aaf161d0.
- R8: While digest_valid_o is high and digest_ready_i is low, digest_valid_o stays high and digest_o does not change.
- R9: On the edge where digest_valid_o and digest_ready_i are both high, the engine returns to idle with the state reset to the initial value. The next block is therefore computed without chaining from the previous one.
- R10: in_valid_i and block_i have no effect while a block is being processed or a digest is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Block offered |
| in_ready_o | output | 1 | Engine idle and able to take a block |
| block_i | input | 512 | Padded block, little-endian words |
| digest_valid_o | output | 1 | Digest available |
| digest_ready_i | input | 1 | Consumer takes the digest |
| digest_o | output | 128 | Digest, byte 0 in the top byte |

## Verification
Some properties are checked on every cycle by the assertions:
- the handshake rules: ready and valid never overlap, and ready drops after an acceptance;
- the step counter advances by one per cycle and produces a valid digest after the last step;
- the digest holds under back-pressure;
- the state is back at the initial value whenever the engine is idle.

Other behaviours can only be shown by the bench scenarios:
- the arithmetic correctness of the digest, checked against known message vectors and against an independent bench model on random blocks;
- the exact 64-cycle latency;
- the initial-value image on the output while the engine is busy;
- the fact that block_i and in_valid_i are ignored while the engine is busy.

// File: rtl/md5_pkg.sv
package md5_pkg;
  localparam int WORD_W       = 32;
  localparam int N_WORDS      = 16;
  localparam int BLOCK_W      = WORD_W * N_WORDS;
  localparam int N_LANES      = 4;
  localparam int DIGEST_W     = WORD_W * N_LANES;
  localparam int N_STEPS      = 64;
  localparam int ROUND_STEPS  = 16;
  localparam int STEP_W       = $clog2(N_STEPS);
  localparam int IDX_W        = $clog2(N_WORDS);
  localparam int SH_W         = $clog2(WORD_W);
  localparam int BYTES_PER_W  = WORD_W / 8;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [STEP_W-1:0] step_t;

  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
  } md5_state_t;

  localparam md5_state_t IV_STATE = '{
    a: 32'h67452301,
    b: 32'hefcdab89,
    c: 32'h98badcfe,
    d: 32'h10325476
  };

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } ctrl_state_e;

  function automatic word_t rotl(word_t x, logic [SH_W-1:0] s);
    return (x << s) | (x >> (6'd32 - {1'b0, s}));
  endfunction

  // message word selected by each step
  function automatic logic [IDX_W-1:0] word_idx(step_t i);
    logic [IDX_W-1:0] j;
    j = i[IDX_W-1:0];
    case (i[STEP_W-1:STEP_W-2])
      2'd0:    return j;
      2'd1:    return j * 4'd5 + 4'd1;
      2'd2:    return j * 4'd3 + 4'd5;
      default: return j * 4'd7;
    endcase
  endfunction

  function automatic logic [SH_W-1:0] shift_amt(step_t i);
    case ({i[STEP_W-1:STEP_W-2], i[1:0]})
      4'h0: return 5'd7;   4'h1: return 5'd12; 4'h2: return 5'd17; 4'h3: return 5'd22;
      4'h4: return 5'd5;   4'h5: return 5'd9;  4'h6: return 5'd14; 4'h7: return 5'd20;
      4'h8: return 5'd4;   4'h9: return 5'd11; 4'ha: return 5'd16; 4'hb: return 5'd23;
      4'hc: return 5'd6;   4'hd: return 5'd10; 4'he: return 5'd15; default: return 5'd21;
    endcase
  endfunction
endpackage

// File: rtl/md5_const_rom.sv
module md5_const_rom
  import md5_pkg::*;
(
  input  step_t step_i,
  output word_t t_o
);
  always_comb begin
    case (step_i)
      6'd0:  t_o = 32'hd76aa478; 6'd1:  t_o = 32'he8c7b756; 6'd2:  t_o = 32'h242070db; 6'd3:  t_o = 32'hc1bdceee;
      6'd4:  t_o = 32'hf57c0faf; 6'd5:  t_o = 32'h4787c62a; 6'd6:  t_o = 32'ha8304613; 6'd7:  t_o = 32'hfd469501;
      6'd8:  t_o = 32'h698098d8; 6'd9:  t_o = 32'h8b44f7af; 6'd10: t_o = 32'hffff5bb1; 6'd11: t_o = 32'h895cd7be;
      6'd12: t_o = 32'h6b901122; 6'd13: t_o = 32'hfd987193; 6'd14: t_o = 32'ha679438e; 6'd15: t_o = 32'h49b40821;
      6'd16: t_o = 32'hf61e2562; 6'd17: t_o = 32'hc040b340; 6'd18: t_o = 32'h265e5a51; 6'd19: t_o = 32'he9b6c7aa;
      6'd20: t_o = 32'hd62f105d; 6'd21: t_o = 32'h02441453; 6'd22: t_o = 32'hd8a1e681; 6'd23: t_o = 32'he7d3fbc8;
      6'd24: t_o = 32'h21e1cde6; 6'd25: t_o = 32'hc33707d6; 6'd26: t_o = 32'hf4d50d87; 6'd27: t_o = 32'h455a14ed;
      6'd28: t_o = 32'ha9e3e905; 6'd29: t_o = 32'hfcefa3f8; 6'd30: t_o = 32'h676f02d9; 6'd31: t_o = 32'h8d2a4c8a;
      6'd32: t_o = 32'hfffa3942; 6'd33: t_o = 32'h8771f681; 6'd34: t_o = 32'h6d9d6122; 6'd35: t_o = 32'hfde5380c;
      6'd36: t_o = 32'ha4beea44; 6'd37: t_o = 32'h4bdecfa9; 6'd38: t_o = 32'hf6bb4b60; 6'd39: t_o = 32'hbebfbc70;
      6'd40: t_o = 32'h289b7ec6; 6'd41: t_o = 32'heaa127fa; 6'd42: t_o = 32'hd4ef3085; 6'd43: t_o = 32'h04881d05;
      6'd44: t_o = 32'hd9d4d039; 6'd45: t_o = 32'he6db99e5; 6'd46: t_o = 32'h1fa27cf8; 6'd47: t_o = 32'hc4ac5665;
      6'd48: t_o = 32'hf4292244; 6'd49: t_o = 32'h432aff97; 6'd50: t_o = 32'hab9423a7; 6'd51: t_o = 32'hfc93a039;
      6'd52: t_o = 32'h655b59c3; 6'd53: t_o = 32'h8f0ccc92; 6'd54: t_o = 32'hffeff47d; 6'd55: t_o = 32'h85845dd1;
      6'd56: t_o = 32'h6fa87e4f; 6'd57: t_o = 32'hfe2ce6e0; 6'd58: t_o = 32'ha3014314; 6'd59: t_o = 32'h4e0811a1;
      6'd60: t_o = 32'hf7537e82; 6'd61: t_o = 32'hbd3af235; 6'd62: t_o = 32'h2ad7d2bb; default: t_o = 32'heb86d391;
    endcase
  end
endmodule

// File: rtl/md5_step.sv
module md5_step
  import md5_pkg::*;
(
  input  md5_state_t cur_i,
  input  step_t      step_i,
  input  word_t      x_i,
  input  word_t      t_i,
  output md5_state_t nxt_o
);
  word_t f;
  word_t sum;
  word_t rot;

  always_comb begin
    case (step_i[STEP_W-1:STEP_W-2])
      2'd0:    f = (cur_i.b & cur_i.c) | (~cur_i.b & cur_i.d);
      2'd1:    f = (cur_i.b & cur_i.d) | (cur_i.c & ~cur_i.d);
      2'd2:    f = cur_i.b ^ cur_i.c ^ cur_i.d;
      default: f = cur_i.c ^ (cur_i.b | ~cur_i.d);
    endcase
    sum = cur_i.a + f + x_i + t_i;
    rot = rotl(sum, shift_amt(step_i));
    // D->A, result->B, B->C, C->D
    nxt_o.a = cur_i.d;
    nxt_o.b = cur_i.b + rot;
    nxt_o.c = cur_i.b;
    nxt_o.d = cur_i.c;
  end
endmodule

// File: rtl/md5_ctrl.sv
module md5_ctrl
  import md5_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  in_valid_i,
  input  logic  digest_ready_i,
  output logic  in_ready_o,
  output logic  digest_valid_o,
  output logic  load_o,
  output logic  step_en_o,
  output logic  last_o,
  output logic  clear_o,
  output step_t step_o
);
  localparam step_t LAST = step_t'(N_STEPS - 1);

  ctrl_state_e state_q, state_d;
  step_t       cnt_q, cnt_d;

  assign in_ready_o     = (state_q == ST_IDLE);
  assign digest_valid_o = (state_q == ST_DONE);
  assign load_o         = in_ready_o && in_valid_i;
  assign step_en_o      = (state_q == ST_RUN);
  assign last_o         = (cnt_q == LAST);
  assign clear_o        = digest_valid_o && digest_ready_i;
  assign step_o         = cnt_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: if (in_valid_i) begin
        state_d = ST_RUN;
        cnt_d   = '0;
      end
      ST_RUN: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) state_d = ST_DONE;
      end
      ST_DONE: if (digest_ready_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  a_r1_ready_valid_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && digest_valid_o));

  a_r3_step_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && cnt_q != LAST) |=> (state_q == ST_RUN && cnt_q == $past(cnt_q) + 1'b1));

  a_r3_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && cnt_q == LAST) |=> digest_valid_o);

  a_r9_take_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (digest_valid_o && digest_ready_i) |=> (in_ready_o && !digest_valid_o));
endmodule

// File: rtl/md5_engine.sv
module md5_engine
  import md5_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [BLOCK_W-1:0]  block_i,
  output logic                digest_valid_o,
  input  logic                digest_ready_i,
  output logic [DIGEST_W-1:0] digest_o
);
  logic       load, step_en, last, clear;
  step_t      step;
  word_t      msg_q [N_WORDS];
  md5_state_t st_q, st_nxt, st_out;
  word_t      t_val;

  md5_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .in_valid_i    (in_valid_i),
    .digest_ready_i(digest_ready_i),
    .in_ready_o    (in_ready_o),
    .digest_valid_o(digest_valid_o),
    .load_o        (load),
    .step_en_o     (step_en),
    .last_o        (last),
    .clear_o       (clear),
    .step_o        (step)
  );

  md5_const_rom u_rom (
    .step_i(step),
    .t_o   (t_val)
  );

  md5_step u_step (
    .cur_i (st_q),
    .step_i(step),
    .x_i   (msg_q[word_idx(step)]),
    .t_i   (t_val),
    .nxt_o (st_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < N_WORDS; j++) msg_q[j] <= '0;
    end else if (load) begin
      for (int j = 0; j < N_WORDS; j++) msg_q[j] <= block_i[j*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= IV_STATE;
    end else if (clear) begin
      st_q <= IV_STATE;
    end else if (step_en) begin
      if (last) begin
        st_q.a <= IV_STATE.a + st_nxt.a;
        st_q.b <= IV_STATE.b + st_nxt.b;
        st_q.c <= IV_STATE.c + st_nxt.c;
        st_q.d <= IV_STATE.d + st_nxt.d;
      end else begin
        st_q <= st_nxt;
      end
    end
  end

  assign st_out = digest_valid_o ? st_q : IV_STATE;

  // little-endian byte order: low byte of A lands in the top byte
  for (genvar w = 0; w < N_LANES; w++) begin : g_lane
    word_t lane;
    assign lane = st_out[DIGEST_W-1-w*WORD_W -: WORD_W];
    for (genvar b = 0; b < BYTES_PER_W; b++) begin : g_byte
      assign digest_o[DIGEST_W-1-(w*BYTES_PER_W+b)*8 -: 8] = lane[b*8 +: 8];
    end
  end

  a_r2_ready_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !in_ready_o);

  a_r8_digest_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (digest_valid_o && !digest_ready_i) |=> (digest_valid_o && $stable(digest_o)));

  a_r9_idle_state_iv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> (st_q == IV_STATE));
endmodule

// File: tb/md5_engine_tb.sv
`timescale 1ns/1ps
module md5_engine_tb;
  localparam logic [127:0] IV_DIG = 128'h0123456789abcdeffedcba9876543210;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [511:0] block = '0;
  logic         dvalid;
  logic         dready = 1'b0;
  logic [127:0] digest;

  int errs = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [31:0] t_tab [64];
  int sh_tab [4][4] = '{'{7,12,17,22}, '{5,9,14,20}, '{4,11,16,23}, '{6,10,15,21}};

  always #2.5 clk = ~clk;

  md5_engine u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .in_valid_i    (in_valid),
    .in_ready_o    (in_ready),
    .block_i       (block),
    .digest_valid_o(dvalid),
    .digest_ready_i(dready),
    .digest_o      (digest)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] pad_str(string s);
    logic [511:0] b = '0;
    for (int n = 0; n < s.len(); n++) b[8*n +: 8] = s[n];
    b[8*s.len() +: 8] = 8'h80;
    b[448 +: 64] = 64'(s.len() * 8);
    return b;
  endfunction

  function automatic logic [127:0] md5_ref(logic [511:0] blk);
    logic [31:0] a, b, c, d, f, tmp;
    logic [31:0] w [4];
    logic [127:0] res;
    int k, s;
    a = 32'h67452301; b = 32'hefcdab89; c = 32'h98badcfe; d = 32'h10325476;
    for (int i = 0; i < 64; i++) begin
      case (i / 16)
        0: begin f = (b & c) | (~b & d); k = i; end
        1: begin f = (b & d) | (c & ~d); k = (5*i + 1) % 16; end
        2: begin f = b ^ c ^ d;          k = (3*i + 5) % 16; end
        default: begin f = c ^ (b | ~d); k = (7*i) % 16; end
      endcase
      s = sh_tab[i/16][i%4];
      tmp = a + f + blk[32*k +: 32] + t_tab[i];
      tmp = (tmp << s) | (tmp >> (32 - s));
      a = d; d = c; c = b; b = b + tmp;
    end
    w[0] = a + 32'h67452301; w[1] = b + 32'hefcdab89;
    w[2] = c + 32'h98badcfe; w[3] = d + 32'h10325476;
    for (int n = 0; n < 16; n++) res[127-8*n -: 8] = w[n/4][8*(n%4) +: 8];
    return res;
  endfunction

  task automatic run_block(input logic [511:0] blk, input logic [127:0] exp,
                           input int hold, input bit junk, input string req);
    @(negedge clk);
    chk(in_ready == 1'b1, "R2 ready before accept", {127'd0, in_ready}, 128'd1);
    in_valid = 1'b1;
    block    = blk;
    @(negedge clk);
    chk(in_ready == 1'b0, "R2 ready low after accept", {127'd0, in_ready}, 128'd0);
    if (junk) block = ~blk ^ {16{$urandom}};
    else begin in_valid = 1'b0; block = {16{$urandom}}; end
    for (int c = 1; c < 64; c++) begin
      @(negedge clk);
      chk(dvalid == 1'b0, "R3 valid low early", {127'd0, dvalid}, 128'd0);
      if (c % 16 == 5) begin
        chk(digest == IV_DIG, "R4 busy output", digest, IV_DIG);
        chk(in_ready == 1'b0, "R10 busy ignores input", {127'd0, in_ready}, 128'd0);
      end
    end
    @(negedge clk);
    chk(dvalid == 1'b1, "R3 valid at 64", {127'd0, dvalid}, 128'd1);
    chk(digest == exp, req, digest, exp);
    in_valid = 1'b0;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(dvalid == 1'b1 && digest == exp, "R8 hold under backpressure", digest, exp);
      chk(in_ready == 1'b0, "R2 ready low while pending", {127'd0, in_ready}, 128'd0);
    end
    dready = 1'b1;
    @(negedge clk);
    dready = 1'b0;
    chk(dvalid == 1'b0 && in_ready == 1'b1, "R9 back to idle", {126'd0, dvalid, in_ready}, 128'd1);
    chk(digest == IV_DIG, "R9 output back to initial", digest, IV_DIG);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [511:0] rb;
    for (int i = 0; i < 64; i++) begin
      real r;
      r = $sin(i + 1);
      if (r < 0.0) r = -r;
      t_tab[i] = 32'(longint'($floor(r * 4294967296.0)));
    end
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    chk(in_ready && !dvalid && digest == IV_DIG, "R1 reset state", digest, IV_DIG);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(in_ready && !dvalid, "R1 idle flags", {126'd0, in_ready, dvalid}, 128'd2);
    chk(digest == IV_DIG, "R1 idle output", digest, IV_DIG);
    chk(digest[127:120] == 8'h01 && digest[7:0] == 8'h10, "R6 byte order idle",
        {112'd0, digest[127:120], digest[7:0]}, {112'd0, 16'h0110});

    // bench model against known vectors
    chk(md5_ref(pad_str("message digest")) == 128'hf96b697d7cb7938d525a2f31aaf161d0,
        "R7 model check", md5_ref(pad_str("message digest")), 128'hf96b697d7cb7938d525a2f31aaf161d0);

    run_block(pad_str("message digest"), 128'hf96b697d7cb7938d525a2f31aaf161d0, 0, 1'b0, "R7 message digest");
    run_block(pad_str(""), 128'hd41d8cd98f00b204e9800998ecf8427e, 3, 1'b1, "R7 empty message");
    run_block(pad_str("abc"), 128'h900150983cd24fb0d6963f7d28e17f72, 1, 1'b0, "R6 R7 abc byte order");

    // corner blocks
    run_block('0, md5_ref('0), 0, 1'b1, "R5 all-zero block");
    run_block('1, md5_ref('1), 2, 1'b0, "R5 all-ones block");

    for (int n = 0; n < 14; n++) begin
      for (int j = 0; j < 16; j++) rb[32*j +: 32] = $urandom;
      run_block(rb, md5_ref(rb), int'($urandom % 4), n[0], "R5 R10 random block");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule